// File: doc/BRIEF.md
# Periodic Divider With Watchdog

This block is a free-running binary divider with a watchdog timer. The divider is a 14-bit up-counter that advances on every base clock. Each time it wraps from all ones to zero, it latches an event flag. The flag is gated by two software enable bits. One gate produces an interrupt request and the other produces a hold-release request. Software can zero the four most significant divider bits while the lower bits keep running. It can also clear the event flag with a strobe.

The watchdog is a 4-bit counter. It steps on rising edges of one of two divider taps: the stage-10 output (base/1024) or the stage-14 output (base/16384). A select bit chooses the tap, and the fast tap is in use while the select bit is low. The watchdog can be enabled only by a static option input. If software fails to clear it before sixteen tap edges pass, the block emits a one-cycle chip reset request and the count restarts from zero.

Tap edges are detected synchronously in the base clock domain, and each tap has its own edge history. Any cycle in which the divider top bits are cleared drops the tap edges of that cycle.

Top module: `tickdiv_watchdog`

## Requirements
- R1: After reset the divider counts up by one per clock, so the first wrap happens 2^DIV_W cycles after reset. In the cycle after a wrap, `evt_flag` reads 1.
- R2: `flag_clr` clears `evt_flag` on the next edge. A wrap in the same cycle wins, and the flag stays 1.
- R3: `int_req` equals `evt_flag` AND `int_en`. `hold_release` equals `evt_flag` AND `hold_en`.
- R4: `div_top_clr` zeroes the top TOP_W divider bits while the low bits keep incrementing. A cycle in which it is asserted never reports a wrap.
- R5: The watchdog gains one count per rising edge of the selected tap. `tap_sel`=0 selects stage TAP_LO (divider bit TAP_LO-1), and this is the default after reset.
- R6: `tap_sel`=1 selects stage TAP_HI (bit TAP_HI-1). Each tap keeps its own edge history, so switching taps never creates an edge.
- R7: On the edge that would take the count past all ones, `wd_reset_req` pulses high for exactly one cycle and the count returns to zero.
- R8: `wd_clear` zeroes the watchdog count and takes priority over a tap edge in the same cycle. No request follows it.
- R9: While `wd_enable` is 0, the count is held at zero and `wd_reset_req` never rises.
- R10: In a cycle with `div_top_clr` asserted, tap edges are discarded.
- R11: During reset, all four outputs are 0.
- R12: With no clears and the fast tap, the first request appears 2^(TAP_LO-1) + 15·2^TAP_LO + 1 cycles after reset. With the bench parameters this is cycle 249.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_enable | input | 1 | Static watchdog enable option |
| tap_sel | input | 1 | Watchdog tap: 0 = fast stage, 1 = slow stage |
| div_top_clr | input | 1 | Strobe: zero the divider top bits |
| wd_clear | input | 1 | Strobe: zero the watchdog count |
| flag_clr | input | 1 | Strobe: clear the event flag |
| int_en | input | 1 | Interrupt enable for the divider event |
| hold_en | input | 1 | Hold-release enable for the divider event |
| evt_flag | output | 1 | Divider wrap event flag |
| int_req | output | 1 | Interrupt request |
| hold_release | output | 1 | Hold-release request |
| wd_reset_req | output | 1 | One-cycle chip reset request |

## Verification
The bench places a flag-clear strobe in the exact cycle of a wrap. A design that lets the clear win there would lose an event. It also toggles `tap_sel` around pending edges, so a design sharing one edge history between taps would count phantom edges and reset early. Top-clear strobes are scattered across both taps. This catches a design that counts the falling top bit as an edge or reports a wrap while the top bits are being cleared. The first request is timed against the exact cycle predicted by R12, the clear strobes are spaced just inside the overflow window, and a disabled instance runs alongside. Between them, an off-by-one edge count, a clear losing to an edge, or a request leaking past the option would each be reported.

// File: rtl/tdw_pkg.sv
package tdw_pkg;

  typedef enum logic {
    TAP_FAST = 1'b0,
    TAP_SLOW = 1'b1
  } tap_sel_e;

  // Synchronous rising-edge qualifier with a kill term.
  function automatic logic tap_rise(input logic prev, input logic now, input logic kill);
    return now & ~prev & ~kill;
  endfunction

endpackage

// File: rtl/tdw_divider.sv
module tdw_divider
  import tdw_pkg::*;
#(
  parameter int DIV_W  = 14,
  parameter int TOP_W  = 4,
  parameter int TAP_LO = 10,
  parameter int TAP_HI = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic top_clr,
  output logic ovf,
  output logic rise_lo,
  output logic rise_hi
);
  localparam int LOW_W = DIV_W - TOP_W;

  logic [DIV_W-1:0] cnt;
  logic             prev_lo, prev_hi;
  logic             tap_lo, tap_hi;

  function automatic logic [DIV_W-1:0] next_count(input logic [DIV_W-1:0] c, input logic clr);
    logic [DIV_W-1:0] n;
    n = c + 1'b1;
    if (clr) n[DIV_W-1:LOW_W] = '0;
    return n;
  endfunction

  assign tap_lo  = cnt[TAP_LO-1];
  assign tap_hi  = cnt[TAP_HI-1];
  assign ovf     = (&cnt) & ~top_clr;
  assign rise_lo = tap_rise(prev_lo, tap_lo, top_clr);
  assign rise_hi = tap_rise(prev_hi, tap_hi, top_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      prev_lo <= 1'b0;
      prev_hi <= 1'b0;
    end else begin
      cnt     <= next_count(cnt, top_clr);
      prev_lo <= tap_lo;
      prev_hi <= tap_hi;
    end
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !top_clr |=> (cnt == DIV_W'($past(cnt) + 1'b1)));
  // R4
  top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_clr |=> (cnt[DIV_W-1:LOW_W] == '0) &&
                (cnt[LOW_W-1:0] == LOW_W'($past(cnt[LOW_W-1:0]) + 1'b1)));

endmodule

// File: rtl/tdw_event.sv
module tdw_event (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic flag_clr,
  input  logic int_en,
  input  logic hold_en,
  output logic evt_flag,
  output logic int_req,
  output logic hold_release
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        evt_flag <= 1'b0;
    else if (ovf)      evt_flag <= 1'b1;
    else if (flag_clr) evt_flag <= 1'b0;
  end

  assign int_req      = evt_flag & int_en;
  assign hold_release = evt_flag & hold_en;

  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> evt_flag);
  // R2
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ovf) |=> !evt_flag);

endmodule

// File: rtl/tdw_watchdog.sv
module tdw_watchdog
  import tdw_pkg::*;
#(
  parameter int WD_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tap_sel,
  input  logic wd_clear,
  input  logic rise_lo,
  input  logic rise_hi,
  output logic rst_req
);
  logic [WD_W-1:0] wd_cnt;
  logic            step;
  logic            wrap;

  assign step = (tap_sel_e'(tap_sel) == TAP_SLOW) ? rise_hi : rise_lo;
  assign wrap = enable & ~wd_clear & step & (&wd_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt  <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wrap;
      if (!enable || wd_clear || wrap) wd_cnt <= '0;
      else if (step)                   wd_cnt <= wd_cnt + 1'b1;
    end
  end

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R7
  zero_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (wd_cnt == '0));
  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clear |=> (wd_cnt == '0) && !rst_req);
  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (wd_cnt == '0) && !rst_req);

endmodule

// File: rtl/tickdiv_watchdog.sv
module tickdiv_watchdog #(
  parameter int DIV_W  = 14,
  parameter int TOP_W  = 4,
  parameter int TAP_LO = 10,
  parameter int TAP_HI = 14,
  parameter int WD_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_enable,
  input  logic tap_sel,
  input  logic div_top_clr,
  input  logic wd_clear,
  input  logic flag_clr,
  input  logic int_en,
  input  logic hold_en,
  output logic evt_flag,
  output logic int_req,
  output logic hold_release,
  output logic wd_reset_req
);
  logic div_ovf;
  logic tap_rise_lo;
  logic tap_rise_hi;

  tdw_divider #(
    .DIV_W (DIV_W),
    .TOP_W (TOP_W),
    .TAP_LO(TAP_LO),
    .TAP_HI(TAP_HI)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .top_clr(div_top_clr),
    .ovf    (div_ovf),
    .rise_lo(tap_rise_lo),
    .rise_hi(tap_rise_hi)
  );

  tdw_event u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovf         (div_ovf),
    .flag_clr    (flag_clr),
    .int_en      (int_en),
    .hold_en     (hold_en),
    .evt_flag    (evt_flag),
    .int_req     (int_req),
    .hold_release(hold_release)
  );

  tdw_watchdog #(
    .WD_W(WD_W)
  ) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (wd_enable),
    .tap_sel (tap_sel),
    .wd_clear(wd_clear),
    .rise_lo (tap_rise_lo),
    .rise_hi (tap_rise_hi),
    .rst_req (wd_reset_req)
  );

  // R10
  no_edge_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_top_clr |-> !div_ovf && !tap_rise_lo && !tap_rise_hi);

endmodule

// File: tb/tb_tickdiv_watchdog.sv
module tb_tickdiv_watchdog;
  localparam int CLK_P   = 10;
  localparam int DIV_W   = 8;
  localparam int TOP_W   = 4;
  localparam int TAP_LO  = 4;
  localparam int TAP_HI  = 8;
  localparam int WD_W    = 4;
  localparam int MOD     = 1 << DIV_W;
  localparam int LOW_MOD = 1 << (DIV_W - TOP_W);
  localparam int WD_MAX  = (1 << WD_W) - 1;
  localparam int NCYC    = 12000;
  localparam int FIRST_REQ = (1 << (TAP_LO - 1)) + 15 * (1 << TAP_LO) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tap_sel = 0, div_top_clr = 0, wd_clear = 0, flag_clr = 0, int_en = 0, hold_en = 0;
  logic evt_flag, int_req, hold_release, wd_reset_req;
  logic off_flag, off_int, off_hold, off_req;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    int k;
    bit flag, irq, hold, req;
  } exp_t;
  exp_t q[$];

  always #(CLK_P / 2) clk = ~clk;

  tickdiv_watchdog #(.DIV_W(DIV_W), .TOP_W(TOP_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI), .WD_W(WD_W)) dut (
    .clk(clk), .rst_n(rst_n), .wd_enable(1'b1), .tap_sel(tap_sel), .div_top_clr(div_top_clr),
    .wd_clear(wd_clear), .flag_clr(flag_clr), .int_en(int_en), .hold_en(hold_en),
    .evt_flag(evt_flag), .int_req(int_req), .hold_release(hold_release), .wd_reset_req(wd_reset_req));

  tickdiv_watchdog #(.DIV_W(DIV_W), .TOP_W(TOP_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI), .WD_W(WD_W)) dut_off (
    .clk(clk), .rst_n(rst_n), .wd_enable(1'b0), .tap_sel(tap_sel), .div_top_clr(div_top_clr),
    .wd_clear(wd_clear), .flag_clr(flag_clr), .int_en(int_en), .hold_en(hold_en),
    .evt_flag(off_flag), .int_req(off_int), .hold_release(off_hold), .wd_reset_req(off_req));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // Reference state (updated by the driver, one step per clock)
  int  m_cnt = 0, m_wd = 0;
  bit  m_plo = 0, m_phi = 0, m_flag = 0;
  int  first_req_k = -1, req_in_b = 0, req_in_c = 0, req_total = 0;

  task automatic model_step(input int k);
    bit tlo, thi, rlo, rhi, ovf, stp, req;
    tlo = ((m_cnt >> (TAP_LO - 1)) & 1) != 0;
    thi = ((m_cnt >> (TAP_HI - 1)) & 1) != 0;
    rlo = tlo && !m_plo && !div_top_clr;   // R10
    rhi = thi && !m_phi && !div_top_clr;   // R6 separate histories
    ovf = (m_cnt == MOD - 1) && !div_top_clr; // R4
    stp = tap_sel ? rhi : rlo;             // R5
    req = 0;
    if (wd_clear) m_wd = 0;                // R8
    else if (stp) begin
      if (m_wd == WD_MAX) begin m_wd = 0; req = 1; end // R7
      else m_wd = m_wd + 1;
    end
    if (ovf) m_flag = 1;                   // R2 set wins
    else if (flag_clr) m_flag = 0;
    m_cnt = (m_cnt + 1) % MOD;
    if (div_top_clr) m_cnt = m_cnt % LOW_MOD;
    m_plo = tlo;
    m_phi = thi;
    q.push_back('{k: k, flag: m_flag, irq: m_flag && int_en, hold: m_flag && hold_en, req: req});
  endtask

  // Monitor: compares after each edge
  always begin
    exp_t e;
    @(posedge clk);
    #(CLK_P / 4);
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(evt_flag == e.flag, "R1/R2 evt_flag", evt_flag, e.flag);
      chk(int_req == e.irq, "R3 int_req", int_req, e.irq);
      chk(hold_release == e.hold, "R3 hold_release", hold_release, e.hold);
      chk(wd_reset_req == e.req, "R7 wd_reset_req", wd_reset_req, e.req);
      chk(off_req == 1'b0, "R9 disabled request", off_req, 0);
      chk(off_flag == e.flag, "R9 disabled instance flag", off_flag, e.flag);
      if (wd_reset_req) begin
        req_total++;
        if (first_req_k < 0) first_req_k = e.k;
        if (e.k >= 600 && e.k < 2000) req_in_b++;
        if (e.k >= 2000 && e.k < 7000) req_in_c++;
      end
    end
  end

  logic [15:0] lf = 16'hACE1;

  task automatic drive(input int k);
    tap_sel = 0; div_top_clr = 0; wd_clear = 0; flag_clr = 0;
    if (k < 600) begin
      int_en = 1; hold_en = 0;
      flag_clr = (k == 300) || (k == 512);   // R2 clear on wrap cycle 512
    end else if (k < 2000) begin
      int_en = 0; hold_en = 1;
      wd_clear = (k % 200 == 0);             // R8
      flag_clr = (k % 150 == 0);
    end else if (k < 7000) begin
      int_en = 1; hold_en = 1; tap_sel = 1;  // R6
      div_top_clr = (k % 700 == 0);          // R4, R10
      flag_clr = (k % 333 == 0);
    end else begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tap_sel = lf[9] ^ lf[3];
      div_top_clr = (lf[4:0] == 5'd7);
      wd_clear = (lf[10:5] == 6'd3);
      flag_clr = (lf[3:0] == 4'd5);
      int_en = lf[11];
      hold_en = lf[14];
    end
  endtask

  initial begin
    #(CLK_P * 3 + 1);
    // R11 reset state
    chk(evt_flag == 0, "R11 evt_flag in reset", evt_flag, 0);
    chk(int_req == 0, "R11 int_req in reset", int_req, 0);
    chk(hold_release == 0, "R11 hold_release in reset", hold_release, 0);
    chk(wd_reset_req == 0, "R11 wd_reset_req in reset", wd_reset_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 1; k <= NCYC; k++) begin
      drive(k);
      model_step(k);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(first_req_k == FIRST_REQ, "R12 first request cycle", first_req_k, FIRST_REQ);
    chk(req_in_b == 0, "R8 requests while cleared in time", req_in_b, 0);
    chk(req_in_c >= 1, "R6 slow-tap request seen", req_in_c, 1);
    chk(req_total >= 3, "R5 fast-tap requests seen", req_total, 3);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (NCYC + 2000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule